// File: doc/BRIEF.md
# PLCP Receive Parity Check and Status Byte Builder

This block watches a received PLCP byte stream and produces the one-byte path status word that the local transmitter sends back to the far end. Across every received frame it accumulates an 8-bit interleaved even parity: each bit lane is the XOR of that lane over all accepted bytes of the frame. When the following frame delivers its parity byte, the stored value is compared lane by lane with that byte. The number of lanes that disagree becomes the block-error count.

That count is packed with a remote alarm bit into the status byte. The alarm is raised once the receiver has stayed out of frame for a programmable number of one-second ticks. The finished byte is presented for one cycle with a valid pulse, once per received frame, for the transmit side to insert into its next outbound frame. Frame alignment is done upstream. The upstream aligner must keep marking the frame start and parity slot positions while alignment is lost.

The input stream carries `rx_valid` only. The block takes a byte on every cycle in which `rx_valid` is high, so there is no back-pressure. The output has no ready signal either: the consumer must capture `g1_byte` in the cycle in which `g1_valid` is high.

Top module: `plcp_g1_builder`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `g1_valid` is 0 and `g1_byte` is 8'h00.
- R2: One cycle after a byte is accepted with `rx_b1`=1 and `rx_sof`=0, `g1_valid` is 1 for exactly one cycle and `g1_byte` takes a new value. At all other times `g1_valid` is 0 and `g1_byte` holds its value.
- R3: The frame parity is the XOR of every byte accepted from one `rx_sof` byte (inclusive) up to the next `rx_sof` byte (exclusive). When a comparison is made, `g1_byte[7:4]` equals the number of set bits in (stored parity XOR the accepted slot byte). This number is never more than 8.
- R4: When the stored parity equals the slot byte, `g1_byte[7:4]` is 0.
- R5: No comparison is made for the first frame that starts after `in_frame` rises, and `g1_byte[7:4]` is 0 for it. A frame counts as observed only if `in_frame` stayed high from its start.
- R6: While `in_frame` is 0, `g1_byte[7:4]` is reported as 0.
- R7: The byte layout is: count in bits 7..4, alarm in bit 3, and bits 2..0 always 3'b000.
- R8: `g1_byte[3]` is 1 when `in_frame` is 0 and the number of `sec_tick` pulses seen since `in_frame` fell is at least the effective threshold.
- R9: The alarm clears as soon as `in_frame` is 1, and the out-of-frame tick count restarts from zero.
- R10: Cycles with `rx_valid`=0 do not contribute to the parity, whatever `rx_data`, `rx_sof` and `rx_b1` hold.
- R11: The effective threshold is `rai_secs` clamped to the range 2..10 seconds. Values below 2 act as 2 and values above 10 act as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_b1 | input | 1 | Byte sits in the parity slot |
| in_frame | input | 1 | Receiver is frame-aligned |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| rai_secs | input | CNT_W (4) | Alarm threshold in seconds |
| g1_valid | output | 1 | One-cycle pulse when g1_byte updates |
| g1_byte | output | 8 | Status byte for the transmit side |

## Verification
The bench uses the default parameters: a 4-bit tick counter with the threshold bounds 2 and 10. The bench chooses short frames of 6 to 12 bytes and drives `sec_tick` directly, so alarm thresholds of ten seconds and counter saturation are reached in a few hundred cycles. Because the counter is 4 bits wide, a `rai_secs` of 15 can be applied, which exercises the upper clamp. Slot bytes are formed as the previous parity XOR a chosen error mask, so every count from 0 to 8 can be produced exactly, including the all-lanes case.

// File: rtl/plcp_g1_pkg.sv
package plcp_g1_pkg;
  localparam int LANES  = 8;
  localparam int CNT_OW = 4;

  typedef struct packed {
    logic [CNT_OW-1:0] febe;
    logic              rai;
    logic [2:0]        spare;
  } g1_t;

  function automatic logic [CNT_OW-1:0] clamp_thr(input int unsigned v,
                                                  input int unsigned lo,
                                                  input int unsigned hi);
    int unsigned r;
    r = (v < lo) ? lo : ((v > hi) ? hi : v);
    return CNT_OW'(r);
  endfunction
endpackage

// File: rtl/bip_lane_accum.sv
module bip_lane_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic [W-1:0] in_data,
  input  logic         in_frame,
  output logic [W-1:0] prev_par,
  output logic         prev_ok
);
  logic [W-1:0] acc;
  logic         armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      prev_par <= '0;
      prev_ok  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (!in_frame) begin
        armed   <= 1'b0;
        prev_ok <= 1'b0;
      end
      if (in_valid) begin
        if (in_sof) begin
          prev_par <= acc;
          prev_ok  <= armed & in_frame;
          armed    <= in_frame;
          acc      <= in_data;
        end else begin
          acc <= acc ^ in_data;
        end
      end
    end
  end
endmodule

// File: rtl/lane_diff_count.sv
module lane_diff_count #(
  parameter int W  = 8,
  parameter int OW = 4
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [OW-1:0] ones
);
  logic [W-1:0] diff;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_lane
      assign diff[g] = a[g] ^ b[g];
    end
  endgenerate

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + OW'(diff[i]);
  end
endmodule

// File: rtl/oof_alarm_timer.sv
module oof_alarm_timer #(
  parameter int CNT_W   = 4,
  parameter int THR_MIN = 2,
  parameter int THR_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame,
  input  logic             sec_tick,
  input  logic [CNT_W-1:0] rai_secs,
  output logic             rai
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] LO      = CNT_W'(THR_MIN);
  localparam logic [CNT_W-1:0] HI      = CNT_W'(THR_MAX);

  logic [CNT_W-1:0] secs;
  logic [CNT_W-1:0] thr_eff;

  always_comb begin
    if (rai_secs < LO)      thr_eff = LO;
    else if (rai_secs > HI) thr_eff = HI;
    else                    thr_eff = rai_secs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           secs <= '0;
    else if (in_frame)                    secs <= '0;
    else if (sec_tick && secs != CNT_TOP) secs <= secs + 1'b1;
  end

  assign rai = !in_frame && (secs >= thr_eff);
endmodule

// File: rtl/plcp_g1_builder.sv
module plcp_g1_builder
  import plcp_g1_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int THR_MIN = 2,
  parameter int THR_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_b1,
  input  logic             in_frame,
  input  logic             sec_tick,
  input  logic [CNT_W-1:0] rai_secs,
  output logic             g1_valid,
  output logic [7:0]       g1_byte
);
  logic [LANES-1:0]  prev_par;
  logic              prev_ok;
  logic [CNT_OW-1:0] diff_cnt;
  logic [CNT_OW-1:0] febe_now;
  logic              rai;
  logic              slot;
  g1_t               g1_q;

  bip_lane_accum #(.W(LANES)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_sof(rx_sof),
    .in_data(rx_data), .in_frame(in_frame),
    .prev_par(prev_par), .prev_ok(prev_ok)
  );

  lane_diff_count #(.W(LANES), .OW(CNT_OW)) u_cnt (
    .a(prev_par), .b(rx_data), .ones(diff_cnt)
  );

  oof_alarm_timer #(.CNT_W(CNT_W), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)) u_rai (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .sec_tick(sec_tick),
    .rai_secs(rai_secs), .rai(rai)
  );

  assign slot     = rx_valid && rx_b1 && !rx_sof;
  assign febe_now = (in_frame && prev_ok) ? diff_cnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g1_q     <= '0;
      g1_valid <= 1'b0;
    end else begin
      g1_valid <= slot;
      if (slot) begin
        g1_q.febe  <= febe_now;
        g1_q.rai   <= rai;
        g1_q.spare <= 3'b000;
      end
    end
  end

  assign g1_byte = g1_q;
endmodule

// File: rtl/plcp_g1_builder_chk.sv
module plcp_g1_builder_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_sof,
  input logic             rx_b1,
  input logic             in_frame,
  input logic             rai_w,
  input logic             g1_valid,
  input logic [7:0]       g1_byte
);
  // R2
  g1_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g1_valid |-> $past(rx_valid && rx_b1 && !rx_sof));

  // R2
  g1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_b1 && !rx_sof) |=> (!g1_valid && $stable(g1_byte)));

  // R3
  febe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g1_byte[7:4] <= 4'd8);

  // R6
  oof_febe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g1_valid && !$past(in_frame)) |-> (g1_byte[7:4] == 4'd0));

  // R9
  rai_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g1_valid && $past(in_frame)) |-> !g1_byte[3]);

  // R7
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g1_byte[2:0] == 3'b000);

  // R8
  rai_needs_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rai_w |-> !in_frame);
endmodule

bind plcp_g1_builder plcp_g1_builder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
  .rx_b1(rx_b1), .in_frame(in_frame), .rai_w(rai),
  .g1_valid(g1_valid), .g1_byte(g1_byte)
);

// File: tb/plcp_g1_builder_test.sv
module plcp_g1_builder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_sof, rx_b1, in_frame, sec_tick;
  logic [7:0] rx_data;
  logic [3:0] rai_secs;
  logic       g1_valid;
  logic [7:0] g1_byte;

  always #2 clk = ~clk;

  plcp_g1_builder uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_b1(rx_b1), .in_frame(in_frame), .sec_tick(sec_tick),
    .rai_secs(rai_secs), .g1_valid(g1_valid), .g1_byte(g1_byte)
  );

  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // independent model of the requirements
  logic [7:0] m_acc = 8'h00, m_prev = 8'h00;
  bit         m_ok = 1'b0, m_armed = 1'b0, m_inf = 1'b0;
  int         m_ticks = 0;

  function automatic int popc(logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  function automatic int thr_eff(logic [3:0] t);
    return (t < 2) ? 2 : ((t > 10) ? 10 : int'(t));
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_data = 8'($urandom);
    rx_sof = $urandom_range(0, 1); rx_b1 = $urandom_range(0, 1);
    sec_tick = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] d, bit sof, bit b1);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = d; rx_sof = sof; rx_b1 = b1; sec_tick = 1'b0;
    if (sof) begin
      m_prev = m_acc; m_ok = m_armed && m_inf; m_armed = m_inf; m_acc = d;
    end else begin
      m_acc = m_acc ^ d;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_sof = 1'b0; rx_b1 = 1'b0; sec_tick = 1'b1;
      if (!m_inf && m_ticks < 15) m_ticks++;
    end
    idle();
  endtask

  task automatic set_frame(bit v);
    @(posedge clk); #1;
    in_frame = v; m_inf = v;
    if (v) m_ticks = 0;
    else begin m_armed = 0; m_ok = 0; end
    idle();
  endtask

  // driver: sends one frame and pushes the expected status byte
  task automatic frame(int len, int b1pos, logic [7:0] mask, int gap, string tag);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      if (gap > 0 && (i % gap) == 1) idle();
      d = 8'($urandom);
      if (i == b1pos) begin
        logic [3:0] fe;
        bit         ra;
        fe = (m_inf && m_ok) ? 4'(popc(mask)) : 4'd0;
        ra = !m_inf && (m_ticks >= thr_eff(rai_secs));
        d  = (m_inf && m_ok) ? (m_prev ^ mask) : mask;
        exp_q.push_back({fe, ra, 3'b000});
        tag_q.push_back(tag);
      end
      put_byte(d, i == 0, i == b1pos);
    end
    idle();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && g1_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected pulse", g1_byte, 8'hxx);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g1_byte === e, {t, " R7"}, g1_byte, e);
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_b1 = 0; rx_data = 0;
    in_frame = 0; sec_tick = 0; rai_secs = 4'd3;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(g1_valid === 1'b0, "R1 valid in reset", {7'd0, g1_valid}, 8'h00);
    check(g1_byte === 8'h00, "R1 byte in reset", g1_byte, 8'h00);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(g1_byte === 8'h00 && g1_valid === 1'b0, "R1 after release", g1_byte, 8'h00);

    set_frame(1);
    frame(8, 3, 8'hFF, 0, "R5 first frame");
    frame(8, 3, 8'h00, 0, "R4 equal");
    frame(10, 2, 8'h81, 0, "R3 two lanes");
    frame(6, 5, 8'hFF, 0, "R3 eight lanes");
    frame(12, 4, 8'h10, 3, "R10 gaps");
    frame(12, 7, 8'h7E, 2, "R3 six lanes");

    set_frame(0);
    frame(8, 3, 8'hFF, 0, "R6 oof count");
    ticks(2);
    frame(8, 3, 8'h0F, 0, "R8 below thr");
    ticks(1);
    frame(8, 3, 8'h0F, 0, "R8 at thr");
    set_frame(1);
    frame(8, 3, 8'h33, 0, "R9 regain");
    frame(8, 3, 8'h03, 0, "R5 second frame");

    rai_secs = 4'd0;
    set_frame(0);
    ticks(1);
    frame(7, 2, 8'h00, 0, "R11 low clamp below");
    ticks(1);
    frame(7, 2, 8'h00, 0, "R11 low clamp at");
    set_frame(1);
    rai_secs = 4'd15;
    set_frame(0);
    ticks(9);
    frame(7, 2, 8'h00, 0, "R11 high clamp below");
    ticks(1);
    frame(7, 2, 8'h00, 0, "R11 high clamp at");
    ticks(6);
    frame(7, 2, 8'h00, 0, "R8 saturated");
    set_frame(1);
    frame(7, 2, 8'h00, 0, "R9 regain again");

    repeat (5) idle();
    check(exp_q.size() == 0, "R2 all updates seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule